// File: doc/BRIEF.md
# Asynchronous Static RAM Controller with Byte Lanes

This block connects a simple internal request port to an external asynchronous static RAM of 524288 words by 16 bits. A requester presents a valid request with a write flag, a 19-bit word address, 16 bits of write data and a 2-bit lane mask. The controller latches the request, drives the RAM's active-low chip, write, output and per-byte enables in a fixed sequence, and returns a one-cycle acknowledge. For reads, the acknowledge comes with the captured data word.

The RAM has no clock, so all timing is counted in controller clock cycles. The read wait is derived from the 10 ns address-to-data access time and the clock period, both given as parameters in picoseconds. The write strobe width is a separate parameter. The data bus is split into an output word, an output-enable and an input word, so the pad-level tristate stays outside the block. The controller drives the bus only while a write is in progress.

Top module: `sram_ctrl_top`

## Requirements
- R1: While reset is asserted and right after it, ramCeN, ramWeN, ramOeN, ramUbN and ramLbN are all 1, ramDoutEn is 0, reqReady is 1 and ack is 0.
- R2: A request is taken only on a clock edge where reqValid and reqReady are both high. reqReady is high only when the controller is idle. A reqValid raised while an access is in progress has no effect on the RAM and produces no acknowledge.
- R3: A write runs in three phases. First comes one setup cycle with ramCeN=0, ramWeN=1 and the data driven. Next ramWeN=0 for WRITE_PULSE_CYC cycles. Last comes one hold cycle with ramWeN=1 and the data still driven. ack is high in the cycle after the hold cycle, which is WRITE_PULSE_CYC+2 cycles after the accepting edge.
- R4: ramAddr is constant while ramCeN is low. During a write, ramDout carries the accepted write data for the whole access.
- R5: Mask bit 0 selects the low byte, data bits 7:0, through ramLbN. Mask bit 1 selects the high byte, bits 15:8, through ramUbN. A lane enable is low only when the access is active and its mask bit is 1. A write stores only the selected bytes, so a mask of 0 leaves the word unchanged.
- R6: A read holds ramCeN=0, ramOeN=0 and ramWeN=1 for READ_WAIT cycles, where READ_WAIT = ceil(ACCESS_PS / CLK_PERIOD_PS). The data is sampled at the edge ending the last of these cycles, and ack and rdData become valid in the next cycle.
- R7: rdData returns 0 in every byte whose mask bit is 0. It returns RAM data in every byte whose mask bit is 1.
- R8: ramDoutEn is never high while ramOeN is low. ramWeN is low only while ramDoutEn is high. ramDoutEn stays high for one cycle after ramWeN returns high.
- R9: When idle, ramCeN, ramOeN, ramWeN, ramUbN and ramLbN are all 1 and ramDoutEn is 0.
- R10: ack is high for exactly one cycle per accepted request. rdData holds its value until the next read capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 19 | Word address |
| reqWdata | input | 16 | Write data |
| reqMask | input | 2 | Lane select, bit 0 = low byte, bit 1 = high byte |
| reqReady | output | 1 | Controller idle, request can be taken |
| ack | output | 1 | One-cycle completion pulse |
| rdData | output | 16 | Captured read data, unselected bytes zero |
| ramAddr | output | 19 | RAM address bus |
| ramCeN | output | 1 | RAM chip enable, active low |
| ramWeN | output | 1 | RAM write enable, active low |
| ramOeN | output | 1 | RAM output enable, active low |
| ramUbN | output | 1 | RAM high-byte enable, active low |
| ramLbN | output | 1 | RAM low-byte enable, active low |
| ramDout | output | 16 | Data driven toward the RAM |
| ramDoutEn | output | 1 | Drive enable for ramDout |
| ramDin | input | 16 | Data returned from the RAM bus |

## Verification
The embedded properties only observe the controller's own outputs. They need nothing from the requester except a clean reset and inputs that are synchronous to clk. The properties also assume the write-pulse parameter is at least one cycle, and the random sequences only use legal parameter values. The bench models the RAM as a behavioural memory. This model commits a write on the rising edge of the write strobe, and only if the bus is still driven at that moment. Disabled lanes and the undriven bus return a garbage pattern, so lane masking and bus-release faults show up at the ports. Requests are always issued at a falling edge and held for one accepting edge. The one exception is the deliberate busy-time request, which is withdrawn before the controller returns to idle.

// File: rtl/sramc_pkg.sv
`timescale 1ns/1ps
package sramc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD
  } ctrlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latch;    // take the request into the holding registers
    logic select;   // access in progress: chip enabled
    logic readEn;   // output enable to the RAM
    logic writeEn;  // write strobe to the RAM
    logic drive;    // controller owns the data bus
    logic capture;  // sample read data at this edge
    logic done;     // access completes at this edge
  } strobes_t;

endpackage

// File: rtl/sramc_ctrl.sv
`timescale 1ns/1ps
module sramc_ctrl
  import sramc_pkg::*;
#(
  parameter int READ_WAIT_CYC   = 2,
  parameter int WRITE_PULSE_CYC = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     reqWrite,
  output logic     reqReady,
  output strobes_t strb
);

  localparam int MAX_CYC = (READ_WAIT_CYC > WRITE_PULSE_CYC) ? READ_WAIT_CYC : WRITE_PULSE_CYC;
  localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(READ_WAIT_CYC - 1);
  localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(WRITE_PULSE_CYC - 1);

  ctrlState_e stateQ, stateD;
  logic [CNT_W-1:0] cntQ, cntD;
  logic accept;

  assign reqReady = (stateQ == ST_IDLE);
  assign accept   = reqValid && reqReady;

  always_comb begin
    stateD = stateQ;
    cntD   = cntQ;
    unique case (stateQ)
      ST_IDLE: begin
        cntD = '0;
        if (accept) stateD = reqWrite ? ST_WSETUP : ST_READ;
      end
      ST_READ: begin
        if (cntQ == RD_LAST) begin
          stateD = ST_IDLE;
          cntD   = '0;
        end else begin
          cntD = cntQ + 1'b1;
        end
      end
      ST_WSETUP: begin
        stateD = ST_WPULSE;
        cntD   = '0;
      end
      ST_WPULSE: begin
        if (cntQ == WR_LAST) begin
          stateD = ST_WHOLD;
          cntD   = '0;
        end else begin
          cntD = cntQ + 1'b1;
        end
      end
      ST_WHOLD: stateD = ST_IDLE;
      default:  stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
    end else begin
      stateQ <= stateD;
      cntQ   <= cntD;
    end
  end

  always_comb begin
    strb.latch   = accept;
    strb.select  = (stateQ != ST_IDLE);
    strb.readEn  = (stateQ == ST_READ);
    strb.writeEn = (stateQ == ST_WPULSE);
    strb.drive   = (stateQ == ST_WSETUP) || (stateQ == ST_WPULSE) || (stateQ == ST_WHOLD);
    strb.capture = (stateQ == ST_READ) && (cntQ == RD_LAST);
    strb.done    = strb.capture || (stateQ == ST_WHOLD);
  end

  // R6
  rd_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_READ && cntQ != RD_LAST) |=> (stateQ == ST_READ));

  // R3
  wr_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_WSETUP) |=> (stateQ == ST_WPULSE));

  // R3
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_WPULSE && cntQ == WR_LAST) |=> (stateQ == ST_WHOLD));

  // R2
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!reqReady && !strb.done) |=> !reqReady);

endmodule

// File: rtl/sramc_dpath.sv
`timescale 1ns/1ps
module sramc_dpath
  import sramc_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16,
  parameter int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqMask,
  output logic              ack,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              ramCeN,
  output logic              ramWeN,
  output logic              ramOeN,
  output logic [LANES-1:0]  laneEnN,
  output logic [DATA_W-1:0] ramDout,
  output logic              ramDoutEn,
  input  logic [DATA_W-1:0] ramDin
);

  localparam int LANE_W = DATA_W / LANES;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [LANES-1:0]  maskQ;
  logic [DATA_W-1:0] rdDataQ;
  logic [DATA_W-1:0] rdMasked;
  logic              ackQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
      maskQ <= '0;
    end else if (strb.latch) begin
      addrQ <= reqAddr;
      dataQ <= reqWdata;
      maskQ <= reqMask;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign rdMasked[l*LANE_W +: LANE_W] = maskQ[l] ? ramDin[l*LANE_W +: LANE_W] : '0;
    assign laneEnN[l] = ~(strb.select & maskQ[l]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdDataQ <= '0;
      ackQ    <= 1'b0;
    end else begin
      ackQ <= strb.done;
      if (strb.capture) rdDataQ <= rdMasked;
    end
  end

  assign ack       = ackQ;
  assign rdData    = rdDataQ;
  assign ramAddr   = addrQ;
  assign ramDout   = dataQ;
  assign ramCeN    = ~strb.select;
  assign ramOeN    = ~strb.readEn;
  assign ramWeN    = ~strb.writeEn;
  assign ramDoutEn = strb.drive;

  // R4
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ramCeN && $past(!ramCeN)) |-> $stable(ramAddr));

  // R4
  wdata_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ramDoutEn && $past(ramDoutEn)) |-> $stable(ramDout));

  // R10
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    ack |=> !ack);

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.capture) |-> $stable(rdData));

endmodule

// File: rtl/sram_ctrl_top.sv
`timescale 1ns/1ps
module sram_ctrl_top
  import sramc_pkg::*;
#(
  parameter int ADDR_W          = 19,
  parameter int DATA_W          = 16,
  parameter int CLK_PERIOD_PS   = 5000,
  parameter int ACCESS_PS       = 10000,
  parameter int WRITE_PULSE_CYC = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [1:0]        reqMask,
  output logic              reqReady,
  output logic              ack,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              ramCeN,
  output logic              ramWeN,
  output logic              ramOeN,
  output logic              ramUbN,
  output logic              ramLbN,
  output logic [DATA_W-1:0] ramDout,
  output logic              ramDoutEn,
  input  logic [DATA_W-1:0] ramDin
);

  localparam int LANES      = 2;
  localparam int RAW_WAIT   = (ACCESS_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int READ_WAIT  = (RAW_WAIT < 1) ? 1 : RAW_WAIT;

  strobes_t strb;
  logic [LANES-1:0] laneEnN;

  sramc_ctrl #(
    .READ_WAIT_CYC  (READ_WAIT),
    .WRITE_PULSE_CYC(WRITE_PULSE_CYC)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .strb    (strb)
  );

  sramc_dpath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .LANES (LANES)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .reqMask  (reqMask),
    .ack      (ack),
    .rdData   (rdData),
    .ramAddr  (ramAddr),
    .ramCeN   (ramCeN),
    .ramWeN   (ramWeN),
    .ramOeN   (ramOeN),
    .laneEnN  (laneEnN),
    .ramDout  (ramDout),
    .ramDoutEn(ramDoutEn),
    .ramDin   (ramDin)
  );

  assign ramLbN = laneEnN[0];
  assign ramUbN = laneEnN[1];

  // R8
  no_contention_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ramDoutEn && !ramOeN));

  // R8
  we_driven_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ramWeN |-> (ramDoutEn && !ramCeN));

  // R8
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ramWeN) |-> ramDoutEn);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ramCeN |-> (ramWeN && ramOeN && ramUbN && ramLbN && !ramDoutEn));

  // R6
  read_we_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ramOeN |-> (ramWeN && !ramCeN));

endmodule

// File: tb/sram_ctrl_top_bench.sv
`timescale 1ns/1ps
module sram_ctrl_top_bench;

  localparam int CLK_NS      = 5;
  localparam int ACCESS_NS   = 10;
  localparam int WPULSE      = 2;
  localparam int RD_WAIT     = (ACCESS_NS + CLK_NS - 1) / CLK_NS;
  localparam int RD_LAT      = RD_WAIT + 1;
  localparam int WR_LAT      = WPULSE + 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [18:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  reqMask = '0;
  logic reqReady, ack;
  logic [15:0] rdData;
  logic [18:0] ramAddr;
  logic ramCeN, ramWeN, ramOeN, ramUbN, ramLbN, ramDoutEn;
  logic [15:0] ramDout, ramDin;

  int checks = 0;
  int errors = 0;

  always #(CLK_NS/2.0) clk = ~clk;

  sram_ctrl_top #(
    .CLK_PERIOD_PS  (CLK_NS * 1000),
    .ACCESS_PS      (ACCESS_NS * 1000),
    .WRITE_PULSE_CYC(WPULSE)
  ) u_sram_ctrl_top (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqMask(reqMask),
    .reqReady(reqReady), .ack(ack), .rdData(rdData),
    .ramAddr(ramAddr), .ramCeN(ramCeN), .ramWeN(ramWeN), .ramOeN(ramOeN),
    .ramUbN(ramUbN), .ramLbN(ramLbN), .ramDout(ramDout), .ramDoutEn(ramDoutEn),
    .ramDin(ramDin)
  );

  // behavioural RAM: commits on the rising write strobe if the bus is still driven
  logic [15:0] devMem [int];
  logic [15:0] refMem [int];

  function automatic logic [15:0] devWord(input logic [18:0] a);
    return devMem.exists(int'(a)) ? devMem[int'(a)] : 16'h0000;
  endfunction

  function automatic logic [15:0] refWord(input logic [18:0] a);
    return refMem.exists(int'(a)) ? refMem[int'(a)] : 16'h0000;
  endfunction

  function automatic logic [15:0] laneMerge(input logic [15:0] oldW, input logic [15:0] newW,
                                            input logic [1:0] m);
    return {m[1] ? newW[15:8] : oldW[15:8], m[0] ? newW[7:0] : oldW[7:0]};
  endfunction

  function automatic logic [15:0] laneZero(input logic [15:0] w, input logic [1:0] m);
    return {m[1] ? w[15:8] : 8'h00, m[0] ? w[7:0] : 8'h00};
  endfunction

  wire rdOn = (ramCeN === 1'b0) && (ramOeN === 1'b0) && (ramWeN === 1'b1);
  assign ramDin = {(rdOn && ramUbN === 1'b0) ? devWord(ramAddr)[15:8] : 8'hA5,
                   (rdOn && ramLbN === 1'b0) ? devWord(ramAddr)[7:0]  : 8'hA5};

  always @(posedge ramWeN) begin
    if (rstN && ramCeN === 1'b0 && ramDoutEn === 1'b1)
      devMem[int'(ramAddr)] = laneMerge(devWord(ramAddr), ramDout, {~ramUbN, ~ramLbN});
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // port monitor, sampled at falling edges
  int weLowCnt = 0;
  int ackCnt = 0;
  int violations = 0;
  logic prevWeN = 1'b1;
  logic prevDoutEn = 1'b0;
  logic [18:0] expAddr = '0;
  logic [15:0] expData = '0;

  always @(negedge clk) begin
    if (rstN) begin
      if (ack) ackCnt++;
      if (ramWeN === 1'b0) weLowCnt++;
      if (ramDoutEn && !ramOeN) violations++;                 // R8 contention
      if (!ramWeN && !ramDoutEn) violations++;                // R8 strobe without data
      if (!prevWeN && ramWeN && !ramDoutEn) violations++;     // R8 hold
      if (ramDoutEn && !prevDoutEn && !ramWeN) violations++;  // R3 setup
      if (!ramCeN && ramAddr !== expAddr) violations++;       // R4 address
      if (ramDoutEn && ramDout !== expData) violations++;     // R4 data
      if (ramCeN && !(ramWeN && ramOeN && ramUbN && ramLbN && !ramDoutEn)) violations++; // R9
      prevWeN = ramWeN;
      prevDoutEn = ramDoutEn;
    end
  end

  task automatic doOp(input bit wr, input logic [18:0] a, input logic [15:0] d,
                      input logic [1:0] m, input bit injectBusy, output logic [15:0] rd);
    int n;
    int ackBefore;
    logic seenLb, seenUb;
    @(negedge clk);
    check(reqReady === 1'b1, "R2 ready before request", reqReady, 1);
    expAddr = a;
    expData = d;
    weLowCnt = 0;
    ackBefore = ackCnt;
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d; reqMask = m;
    @(posedge clk);
    @(negedge clk);
    n = 1;
    seenLb = ramLbN; seenUb = ramUbN;
    if (injectBusy) begin
      reqWrite = 1'b1; reqAddr = a ^ 19'h00040; reqWdata = ~d; reqMask = 2'b11;
      check(reqReady === 1'b0, "R2 busy ready low", reqReady, 0);
    end else begin
      reqValid = 1'b0;
    end
    while (ack !== 1'b1 && n < 50) begin
      @(negedge clk);
      n++;
      if (n >= 2) reqValid = 1'b0;
    end
    reqValid = 1'b0;
    check(n == (wr ? WR_LAT : RD_LAT), wr ? "R3 write latency" : "R6 read latency", n,
          wr ? WR_LAT : RD_LAT);
    check({seenUb, seenLb} === ~m, "R5 lane enables", {seenUb, seenLb}, ~m);
    if (wr) check(weLowCnt == WPULSE, "R3 strobe width", weLowCnt, WPULSE);
    rd = rdData;
    @(negedge clk);
    check(ack === 1'b0 && ackCnt == ackBefore + 1, "R10 single ack", ackCnt - ackBefore, 1);
    check(rdData === rd, "R10 rdData held", rdData, rd);
    check(ramCeN && ramOeN && ramWeN && ramUbN && ramLbN && !ramDoutEn, "R9 idle strobes",
          {ramCeN, ramOeN, ramWeN, ramUbN, ramLbN, ramDoutEn}, 6'b111110);
  endtask

  task automatic wr(input logic [18:0] a, input logic [15:0] d, input logic [1:0] m);
    logic [15:0] dummy;
    doOp(1'b1, a, d, m, 1'b0, dummy);
    refMem[int'(a)] = laneMerge(refWord(a), d, m);
  endtask

  task automatic rdChk(input logic [18:0] a, input logic [1:0] m, input string tag);
    logic [15:0] got;
    logic [15:0] exp;
    doOp(1'b0, a, 16'h0000, m, 1'b0, got);
    exp = laneZero(refWord(a), m);
    check(got === exp, tag, got, exp);
  endtask

  logic [18:0] pool [8];

  initial begin
    logic [15:0] dummy;
    void'($urandom(32'd20240611));
    // R1 reset state
    repeat (3) @(negedge clk);
    check(ramCeN && ramWeN && ramOeN && ramUbN && ramLbN && !ramDoutEn && reqReady && !ack,
          "R1 reset outputs", {ramCeN, ramWeN, ramOeN, ramUbN, ramLbN, ramDoutEn, reqReady, ack},
          8'b11111010);
    rstN = 1'b1;
    @(negedge clk);
    check(ramCeN && !ramDoutEn && reqReady && !ack, "R1 after reset",
          {ramCeN, ramDoutEn, reqReady, ack}, 4'b1010);

    // directed corners
    wr(19'h00000, 16'h1234, 2'b11);
    rdChk(19'h00000, 2'b11, "R6 full read");
    rdChk(19'h00000, 2'b01, "R7 low lane only");
    rdChk(19'h00000, 2'b10, "R7 high lane only");
    rdChk(19'h00000, 2'b00, "R7 no lanes");
    wr(19'h00000, 16'hFFFF, 2'b00);
    rdChk(19'h00000, 2'b11, "R5 zero mask write unchanged");
    wr(19'h7FFFF, 16'hBEEF, 2'b11);
    wr(19'h7FFFF, 16'h00C3, 2'b01);
    rdChk(19'h7FFFF, 2'b11, "R5 low byte write at top address");
    wr(19'h7FFFF, 16'h5A00, 2'b10);
    rdChk(19'h7FFFF, 2'b11, "R5 high byte write");

    // R2 request during a busy write is ignored
    doOp(1'b1, 19'h00100, 16'hCAFE, 2'b11, 1'b1, dummy);
    refMem[int'(19'h00100)] = laneMerge(refWord(19'h00100), 16'hCAFE, 2'b11);
    rdChk(19'h00140, 2'b11, "R2 busy write ignored");
    rdChk(19'h00100, 2'b11, "R2 accepted write intact");
    doOp(1'b0, 19'h00100, 16'h0000, 2'b11, 1'b1, dummy);
    rdChk(19'h00140, 2'b11, "R2 busy during read ignored");

    // constrained random
    for (int i = 0; i < 8; i++) pool[i] = 19'($urandom);
    pool[0] = 19'h00000;
    pool[7] = 19'h7FFFF;
    for (int i = 0; i < 300; i++) begin
      logic [18:0] a;
      a = pool[$urandom % 8];
      if ($urandom % 2) wr(a, 16'($urandom), 2'($urandom));
      else rdChk(a, 2'($urandom), "R7 random read");
    end

    check(violations == 0, "R8 bus and strobe monitor", violations, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_NS * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule